// File: doc/BRIEF.md
# Memory Scan Controller with CRC Feed

This block walks a range of program-memory word addresses, from a low bound up to a high bound, and hands each fetched word to a CRC engine over a valid/ready handshake. It shares the memory with a CPU. A two-bit mode input selects one of four arbitration policies. The CPU can be held for the whole scan. It can be held only while each word is read. The scan can be started by an external trigger edge. Or the scanner can borrow only those cycles in which the CPU leaves the memory idle.

Software sees the block through register-style inputs: enable, a start strobe, a clear strobe, the mode and the two bounds. It watches a busy flag, an interrupt flag and an invalid flag. A scan ends in one of five ways:
- the last word is delivered;
- an unimplemented address is reached;
- the CRC engine is switched off, which is an abort;
- software clears it, except in full-stall mode;
- the block is disabled.

Top module: `mem_scan_ctrl`

## Requirements
- R1: Out of reset, scan_busy, cpu_stall, crc_valid, irq_flag and invalid are 0. A go_set pulse while scan_en=1 and scan_busy=0 raises scan_busy on the next edge and latches mode, where 00 = interleaved stall, 01 = full stall, 10 = idle-cycle and 11 = triggered. The first word read is at lo_addr.
- R2: In mode 01, cpu_stall is 1 in every cycle in which scan_busy is 1, and go_clr has no effect.
- R3: In mode 00, cpu_stall equals mem_rd_en. After every accepted word, the next cycle carries no read.
- R4: In mode 11, no read happens after go_set until trig_in is sampled high one cycle after it was sampled low. After that the mode behaves as mode 00.
- R5: In mode 10, mem_rd_en is only 1 in cycles where cpu_idle=1, and cpu_stall stays 0.
- R6: While scan_busy=1, if crc_en or crc_go is 0, scan_busy falls on the next edge and invalid is set. invalid is cleared by the next accepted go_set.
- R7: After start, no read happens until crc_ready has been sampled high once. A word is accepted when crc_valid and crc_ready are both 1. crc_data equals mem_rdata. Accepted addresses rise by one.
- R8: The scan ends after the word at an address >= hi_addr is accepted. When lo_addr > hi_addr, only the word at lo_addr is delivered.
- R9: If mem_unimpl is 1 while the scanner is reading words, no word is delivered from that address and the scan ends without invalid.
- R10: irq_flag sets on the edge where scan_busy falls, except when scan_en=0. Only irq_clr clears it, and a set in the same cycle wins over the clear.
- R11: In modes 00, 10 and 11, go_clr ends the scan on the next edge without setting invalid.
- R12: scan_en=0 drops scan_busy on the next edge and resets the sequencing state. It does not set irq_flag and it leaves invalid unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Scanner enable |
| go_set | input | 1 | Start strobe |
| go_clr | input | 1 | Software stop strobe |
| mode | input | 2 | Access mode |
| lo_addr | input | 22 | First word address |
| hi_addr | input | 22 | Last word address |
| crc_en | input | 1 | CRC engine enabled |
| crc_go | input | 1 | CRC engine running |
| crc_ready | input | 1 | CRC engine accepts a word |
| trig_in | input | 1 | Selected trigger source |
| cpu_idle | input | 1 | CPU does not use memory this cycle |
| irq_clr | input | 1 | Interrupt flag clear strobe |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 22 | Memory word address |
| mem_rdata | input | 16 | Memory read data, same cycle |
| mem_unimpl | input | 1 | mem_addr is unimplemented |
| crc_valid | output | 1 | Word offered to the CRC engine |
| crc_data | output | 16 | Word to the CRC engine |
| cpu_stall | output | 1 | Hold the CPU |
| scan_busy | output | 1 | Scan in progress |
| irq_flag | output | 1 | Scan-finished interrupt flag |
| invalid | output | 1 | Scan was aborted |

## Verification
The hardest case to reach from the ports is a scan that ends while the CRC engine is stalling it. Here the abort, unimplemented-address or software-clear condition must win over a transfer that is pending in the same cycle. The stimulus reaches it with a background pattern generator that holds crc_ready low and then toggles it, and with cpu_idle asserted only one cycle in three. The control strobes are then pulsed a fixed number of cycles into a long scan. A behavioural model in the bench predicts every output on every cycle, so each of these collisions is compared cycle by cycle.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [1:0] {
        MODE_CONC  = 2'b00,
        MODE_BURST = 2'b01,
        MODE_PEEK  = 2'b10,
        MODE_TRIG  = 2'b11
    } scan_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_WTRIG = 2'b01,
        ST_WRDY  = 2'b10,
        ST_RUN   = 2'b11
    } scan_state_e;

    // Modes that stall the CPU only for the read cycle and leave a gap after it
    function automatic logic is_interleaved(scan_mode_e m);
        return (m == MODE_CONC) || (m == MODE_TRIG);
    endfunction

    // Modes in which software may stop a running scan
    function automatic logic sw_stop_allowed(scan_mode_e m);
        return m != MODE_BURST;
    endfunction

    function automatic scan_state_e start_state(scan_mode_e m);
        return (m == MODE_TRIG) ? ST_WTRIG : ST_WRDY;
    endfunction

endpackage

// File: rtl/scan_addr_gen.sv
module scan_addr_gen #(
    parameter int AW = 22
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    output logic [AW-1:0] addr,
    output logic          at_end
);
    always_ff @(posedge clk) begin
        if (rst)       addr <= '0;
        else if (load) addr <= lo;
        else if (step) addr <= addr + 1'b1;
    end

    // >= covers both the normal last word and a low bound above the high bound
    assign at_end = (addr >= hi);
endmodule

// File: rtl/scan_slot_arb.sv
module scan_slot_arb
    import scan_pkg::*;
#(
    parameter int GAP = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       running,
    input  scan_mode_e mode,
    input  logic       cpu_idle,
    input  logic       xfer,
    input  logic       trig_in,
    output logic       slot,
    output logic       trig_rise
);
    localparam int GW = (GAP < 1) ? 1 : $clog2(GAP + 1);

    logic [GW-1:0] gap_q;
    logic          trig_q;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= trig_in;
    end
    assign trig_rise = trig_in & ~trig_q;

    generate
        if (GAP > 0) begin : g_gap
            always_ff @(posedge clk) begin
                if (rst || !running)                  gap_q <= '0;
                else if (xfer && is_interleaved(mode)) gap_q <= GW'(GAP);
                else if (gap_q != '0)                  gap_q <= gap_q - 1'b1;
            end
        end else begin : g_nogap
            always_ff @(posedge clk) gap_q <= '0;
        end
    endgenerate

    always_comb begin
        slot = running && (gap_q == '0);
        if (mode == MODE_PEEK) slot = slot && cpu_idle;
    end
endmodule

// File: rtl/mem_scan_ctrl.sv
module mem_scan_ctrl
    import scan_pkg::*;
#(
    parameter int AW  = 22,
    parameter int DW  = 16,
    parameter int GAP = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scan_en,
    input  logic          go_set,
    input  logic          go_clr,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] lo_addr,
    input  logic [AW-1:0] hi_addr,
    input  logic          crc_en,
    input  logic          crc_go,
    input  logic          crc_ready,
    input  logic          trig_in,
    input  logic          cpu_idle,
    input  logic          irq_clr,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_unimpl,
    output logic          crc_valid,
    output logic [DW-1:0] crc_data,
    output logic          cpu_stall,
    output logic          scan_busy,
    output logic          irq_flag,
    output logic          invalid
);
    scan_state_e state_q, state_n;
    scan_mode_e  mode_q, mode_n;
    logic        go_q, go_n;
    logic        inv_q, inv_n;
    logic        irq_q, irq_n;

    logic          start, crc_ok, running, xfer, slot, trig_rise, at_end, irq_set;
    logic [AW-1:0] addr;

    assign start   = scan_en && !go_q && go_set;
    assign crc_ok  = crc_en && crc_go;
    assign running = (state_q == ST_RUN);

    scan_addr_gen #(.AW(AW)) u_addr (
        .clk(clk), .rst(rst), .load(start), .step(xfer),
        .lo(lo_addr), .hi(hi_addr), .addr(addr), .at_end(at_end)
    );

    scan_slot_arb #(.GAP(GAP)) u_arb (
        .clk(clk), .rst(rst), .running(running), .mode(mode_q),
        .cpu_idle(cpu_idle), .xfer(xfer), .trig_in(trig_in),
        .slot(slot), .trig_rise(trig_rise)
    );

    // Datapath and handshake
    assign crc_valid = slot && !mem_unimpl && crc_ok && scan_en;
    assign xfer      = crc_valid && crc_ready;
    assign mem_rd_en = crc_valid;
    assign mem_addr  = addr;
    assign crc_data  = mem_rdata;
    assign cpu_stall = go_q && ((mode_q == MODE_BURST) ||
                                (is_interleaved(mode_q) && crc_valid));

    // Sequencing: the end conditions are listed in priority order
    always_comb begin
        state_n = state_q;
        mode_n  = mode_q;
        go_n    = go_q;
        inv_n   = inv_q;
        irq_set = 1'b0;
        if (!scan_en) begin
            state_n = ST_IDLE;
            go_n    = 1'b0;
        end else if (!go_q) begin
            if (go_set) begin
                mode_n  = scan_mode_e'(mode);
                state_n = start_state(scan_mode_e'(mode));
                go_n    = 1'b1;
                inv_n   = 1'b0;
            end
        end else if (!crc_ok) begin
            state_n = ST_IDLE;
            go_n    = 1'b0;
            inv_n   = 1'b1;
            irq_set = 1'b1;
        end else if ((running && mem_unimpl) || (xfer && at_end) ||
                     (go_clr && sw_stop_allowed(mode_q))) begin
            state_n = ST_IDLE;
            go_n    = 1'b0;
            irq_set = 1'b1;
        end else begin
            case (state_q)
                ST_WTRIG: if (trig_rise) state_n = ST_WRDY;
                ST_WRDY:  if (crc_ready) state_n = ST_RUN;
                default:  ;
            endcase
        end
        irq_n = (irq_q && !irq_clr) || irq_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_CONC;
            go_q    <= 1'b0;
            inv_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            mode_q  <= mode_n;
            go_q    <= go_n;
            inv_q   <= inv_n;
            irq_q   <= irq_n;
        end
    end

    assign scan_busy = go_q;
    assign irq_flag  = irq_q;
    assign invalid   = inv_q;
endmodule

// File: rtl/scan_ctrl_chk.sv
module scan_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       scan_en,
    input logic       go_q,
    input logic [1:0] mode_q,
    input logic       cpu_stall,
    input logic       mem_rd_en,
    input logic       cpu_idle,
    input logic       crc_en,
    input logic       crc_go,
    input logic       invalid,
    input logic       irq_flag,
    input logic       irq_clr,
    input logic       mem_unimpl
);
    p_burst_stall_r2: assert property (@(posedge clk) disable iff (rst)
        (go_q && mode_q == 2'b01) |-> cpu_stall);

    p_conc_stall_r3: assert property (@(posedge clk) disable iff (rst)
        (go_q && mode_q == 2'b00) |-> (cpu_stall == mem_rd_en));

    p_peek_nostall_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'b10) |-> !cpu_stall);

    p_peek_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && mode_q == 2'b10) |-> cpu_idle);

    p_abort_r6: assert property (@(posedge clk) disable iff (rst)
        (go_q && scan_en && !(crc_en && crc_go)) |=> (!go_q && invalid));

    p_read_crc_r7: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (crc_en && crc_go));

    p_no_unimpl_r9: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> !mem_unimpl);

    p_irq_on_end_r10: assert property (@(posedge clk) disable iff (rst)
        (go_q && scan_en) |=> (go_q || irq_flag));

    p_irq_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !irq_clr) |=> irq_flag);

    p_disable_r12: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> !go_q);
endmodule

bind mem_scan_ctrl scan_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .scan_en(scan_en), .go_q(go_q), .mode_q(mode_q),
    .cpu_stall(cpu_stall), .mem_rd_en(mem_rd_en), .cpu_idle(cpu_idle),
    .crc_en(crc_en), .crc_go(crc_go), .invalid(invalid), .irq_flag(irq_flag),
    .irq_clr(irq_clr), .mem_unimpl(mem_unimpl)
);

// File: tb/sim_mem_scan_ctrl.sv
module sim_mem_scan_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic        scan_en = 1'b1, go_set = 1'b0, go_clr = 1'b0, irq_clr = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [21:0] lo_addr = '0, hi_addr = '0, unimpl_base = 22'h3FFFFF;
    logic        crc_en = 1'b1, crc_go = 1'b1, crc_ready = 1'b1;
    logic        trig_in = 1'b0, cpu_idle = 1'b1;
    logic        mem_rd_en, mem_unimpl, crc_valid, cpu_stall, scan_busy, irq_flag, invalid;
    logic [21:0] mem_addr;
    logic [15:0] mem_rdata, crc_data;

    assign mem_rdata  = mem_addr[15:0] ^ 16'h5A3C;
    assign mem_unimpl = (mem_addr >= unimpl_base);

    mem_scan_ctrl u0 (
        .clk(clk), .rst(rst), .scan_en(scan_en), .go_set(go_set), .go_clr(go_clr),
        .mode(mode), .lo_addr(lo_addr), .hi_addr(hi_addr), .crc_en(crc_en),
        .crc_go(crc_go), .crc_ready(crc_ready), .trig_in(trig_in), .cpu_idle(cpu_idle),
        .irq_clr(irq_clr), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_unimpl(mem_unimpl), .crc_valid(crc_valid),
        .crc_data(crc_data), .cpu_stall(cpu_stall), .scan_busy(scan_busy),
        .irq_flag(irq_flag), .invalid(invalid)
    );

    int checks = 0, fails = 0, rdy_pat = 0, idle_pat = 0;
    logic [21:0] got[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model state
    int          m_st = 0;
    bit          m_go = 0, m_inv = 0, m_irq = 0, m_gap = 0, m_tprev = 0;
    logic [21:0] m_addr = '0;
    logic [1:0]  m_mode = 2'b00;
    int          n_st;
    bit          n_go, n_inv, n_irq, n_gap, n_tprev;
    logic [21:0] n_addr;
    logic [1:0]  n_mode;
    bit          prev_x = 0;
    int          gap_viol = 0;

    always @(negedge clk) begin
        if (!rst) begin
            bit crc_ok, run, unimp, slot, v, x, stall, inter, setirq;
            string stag;
            crc_ok = crc_en && crc_go;
            run    = (m_st == 3);
            unimp  = (m_addr >= unimpl_base);
            inter  = (m_mode == 2'b00) || (m_mode == 2'b11);
            slot   = run && !m_gap && (m_mode != 2'b10 || cpu_idle);
            v      = slot && !unimp && crc_ok && scan_en;
            x      = v && crc_ready;
            stall  = m_go && (m_mode == 2'b01 || (inter && v));
            stag   = (m_mode == 2'b01) ? "R2 stall" : (m_mode == 2'b10) ? "R5 stall" :
                     (m_mode == 2'b11) ? "R4 stall" : "R3 stall";
            chk(scan_busy == m_go, "R1 busy", scan_busy, m_go);
            chk(invalid == m_inv, "R6 invalid", invalid, m_inv);
            chk(irq_flag == m_irq, "R10 irq", irq_flag, m_irq);
            chk(cpu_stall == stall, stag, cpu_stall, stall);
            chk(crc_valid == v, "R7 valid", crc_valid, v);
            if (v) begin
                chk(mem_addr == m_addr, "R7 addr", mem_addr, m_addr);
                chk(crc_data == (m_addr[15:0] ^ 16'h5A3C), "R7 data", crc_data, m_addr[15:0] ^ 16'h5A3C);
            end
            if (crc_valid && crc_ready) begin
                got.push_back(mem_addr);
                if (prev_x && inter) gap_viol++;
            end
            prev_x = crc_valid && crc_ready;
            // next state
            n_st = m_st; n_go = m_go; n_inv = m_inv; n_mode = m_mode; n_addr = m_addr;
            n_tprev = trig_in; n_gap = x && inter; setirq = 0;
            if (x) n_addr = m_addr + 1;
            if (!scan_en) begin
                n_st = 0; n_go = 0;
            end else if (!m_go) begin
                if (go_set) begin
                    n_mode = mode; n_st = (mode == 2'b11) ? 1 : 2; n_go = 1; n_inv = 0; n_addr = lo_addr;
                end
            end else if (!crc_ok) begin
                n_st = 0; n_go = 0; n_inv = 1; setirq = 1;
            end else if ((run && unimp) || (x && m_addr >= hi_addr) || (go_clr && m_mode != 2'b01)) begin
                n_st = 0; n_go = 0; setirq = 1;
            end else if (m_st == 1 && trig_in && !m_tprev) n_st = 2;
            else if (m_st == 2 && crc_ready) n_st = 3;
            n_irq = (m_irq && !irq_clr) || setirq;
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            m_st <= 0; m_go <= 0; m_inv <= 0; m_irq <= 0; m_gap <= 0; m_tprev <= 0;
            m_addr <= '0; m_mode <= 2'b00;
        end else begin
            m_st <= n_st; m_go <= n_go; m_inv <= n_inv; m_irq <= n_irq; m_gap <= n_gap;
            m_tprev <= n_tprev; m_addr <= n_addr; m_mode <= n_mode;
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic sample();
        @(negedge clk);
    endtask

    // Background patterns for crc_ready and cpu_idle
    initial begin
        int cnt = 0;
        forever begin
            @(posedge clk); #2;
            cnt++;
            crc_ready = (rdy_pat == 0) ? 1'b1 : (rdy_pat == 1) ? cnt[0] : 1'b0;
            cpu_idle  = (idle_pat == 0) ? 1'b1 : ((cnt % 3) == 0);
        end
    end

    task automatic start(input logic [1:0] m, input int lo, input int hi);
        got.delete();
        mode = m; lo_addr = 22'(lo); hi_addr = 22'(hi);
        go_set = 1'b1; tick(); go_set = 1'b0;
    endtask

    task automatic pulse_irq_clr();
        irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            sample();
            if (!scan_busy) break;
            tick();
        end
        sample();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        sample();
        chk(!scan_busy && !cpu_stall && !crc_valid && !irq_flag && !invalid, "R1 reset", scan_busy, 0);
        tick();

        // R2: full stall, software clear ignored
        start(2'b01, 10, 17);
        tick(); tick(); go_clr = 1'b1; tick(); go_clr = 1'b0;
        wait_idle();
        chk(got.size() == 8, "R2 words despite go_clr", got.size(), 8);
        chk(got.size() > 0 && got[got.size()-1] == 17, "R8 last word", got.size() > 0 ? got[got.size()-1] : -1, 17);
        chk(irq_flag && !invalid, "R10 irq after end", irq_flag, 1);
        tick(); pulse_irq_clr(); sample();
        chk(!irq_flag, "R10 irq cleared", irq_flag, 0);
        tick();

        // R7 and R3: CRC engine not ready at first, then ready every other cycle
        rdy_pat = 2;
        start(2'b00, 100, 105);
        repeat (6) tick();
        sample();
        chk(got.size() == 0, "R7 wait for ready", got.size(), 0);
        tick(); rdy_pat = 1;
        wait_idle();
        chk(got.size() == 6 && got[0] == 100, "R3 words", got.size(), 6);
        chk(gap_viol == 0, "R3 gap after word", gap_viol, 0);
        rdy_pat = 0; tick(); pulse_irq_clr();

        // R4: triggered mode
        start(2'b11, 200, 203);
        repeat (10) tick();
        sample();
        chk(got.size() == 0 && scan_busy, "R4 waits for trigger", got.size(), 0);
        tick(); trig_in = 1'b1; tick(); trig_in = 1'b0;
        wait_idle();
        chk(got.size() == 4 && got[3] == 203, "R4 words after trigger", got.size(), 4);
        tick(); pulse_irq_clr();

        // R5: idle-cycle mode
        idle_pat = 1;
        start(2'b10, 0, 5);
        wait_idle();
        chk(got.size() == 6, "R5 words", got.size(), 6);
        idle_pat = 0; tick(); pulse_irq_clr();

        // R8: low bound above high bound
        start(2'b00, 50, 40);
        wait_idle();
        chk(got.size() == 1 && got[0] == 50, "R8 single word", got.size(), 1);
        tick(); pulse_irq_clr();

        // R9: unimplemented address ends the scan
        unimpl_base = 22'd300;
        start(2'b01, 296, 310);
        wait_idle();
        chk(got.size() == 4 && got[3] == 299, "R9 stop at unimpl", got.size(), 4);
        chk(irq_flag && !invalid, "R9 no invalid", invalid, 0);
        unimpl_base = 22'h3FFFFF; tick(); pulse_irq_clr();

        // R6: CRC go dropped mid-scan
        start(2'b00, 400, 499);
        repeat (6) tick();
        crc_go = 1'b0; tick(); crc_go = 1'b1;
        sample();
        chk(!scan_busy && invalid, "R6 abort", invalid, 1);
        chk(irq_flag, "R10 irq on abort", irq_flag, 1);
        chk(got.size() < 100, "R6 partial", got.size(), 3);
        tick(); pulse_irq_clr();
        start(2'b00, 500, 501);
        sample();
        chk(!invalid, "R6 invalid cleared by start", invalid, 0);
        wait_idle(); tick(); pulse_irq_clr();

        // R11: software clear in interleaved mode
        start(2'b00, 600, 699);
        repeat (5) tick();
        go_clr = 1'b1; tick(); go_clr = 1'b0;
        sample();
        chk(!scan_busy && !invalid && irq_flag, "R11 sw stop", scan_busy, 0);
        tick(); pulse_irq_clr();

        // R12: disable mid-scan
        start(2'b01, 700, 799);
        repeat (5) tick();
        scan_en = 1'b0; tick();
        sample();
        chk(!scan_busy && !irq_flag, "R12 disable", irq_flag, 0);
        tick(); scan_en = 1'b1;
        start(2'b01, 700, 702);
        wait_idle();
        chk(got.size() == 3 && got[0] == 700, "R12 restart", got.size(), 3);

        repeat (3) tick();
        finish_run();
    end
endmodule